// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter with Torn-Read Detection

A free-running cycle counter, 64 bits wide by default, that a 32-bit register bus reads as two separate words. The two halves cannot be read in one access, so the counter may carry into the upper word between the two reads, or an interrupt may run between them. The counter is never frozen or latched for the read. Instead a small tracking state machine watches each lower-word-then-upper-word access pair. It then reports, in one status bit of the control register, whether the two values it returned belong to the same counter value.

Software reads the lower word, then the upper word, then the control register. It repeats those three reads until the status bit is set. The processor's exception logic is reduced here to one input pulse, `exc_i`, which is high in any cycle in which an interrupt or exception is taken. The counter is held while disabled and only counts once software sets the enable bit.

Register indices are parameters: control at 0x103, lower word at 0x104, upper word at 0x105. A read is sampled on a rising edge. Its data appears on `rdata_o`, with `rvalid_o` high, from that edge until the next one. The data is the counter value as it stood just before that edge.

Top module: `snap_counter`

## Requirements
- R1: While enabled, the counter increases by exactly one every clock cycle, with the carry crossing from the lower word into the upper word.
- R2: After reset the counter is zero, the counter is disabled, the status bit is clear and `rdata_o`/`rvalid_o` are zero.
- R3: A write to the control index copies `wdata_i[0]` into the enable bit. Control bit 0 reads back the enable bit. While the counter is disabled it holds its value.
- R4: A read of the lower-word index returns counter bits [WORD_W-1:0], and a read of the upper-word index returns bits [2*WORD_W-1:WORD_W]. Each result is the pre-edge counter value and is presented with `rvalid_o` one cycle after the read is sampled.
- R5: Control bit WORD_W-1 (bit 31 by default) is the status bit. It is set after an upper-word read that follows a lower-word read when the upper word is unchanged and no exception was taken in between.
- R6: An `exc_i` pulse in any cycle after the lower-word read, up to and including the cycle of the upper-word read, makes that pair report a clear status. A pulse in the lower-word read's own cycle, or while no pair is open, has no effect on the pair.
- R7: If the upper word differs at the upper-word read from its value at the lower-word read, the pair reports a clear status.
- R8: A lower-word read clears the status bit and starts a new pair, discarding any open one.
- R9: An upper-word read with no open pair leaves the status bit clear.
- R10: Reading the control register does not change the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read strobe for `addr_i` |
| wr_en_i | input | 1 | Write strobe for `addr_i` |
| addr_i | input | ADDR_W | Register index |
| wdata_i | input | WORD_W | Write data |
| exc_i | input | 1 | High in any cycle in which an interrupt or exception is taken |
| rdata_o | output | WORD_W | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle after the read |

## Verification
Every read result is due exactly one cycle after the edge that samples the read. It carries the counter value from just before that edge. The status bit seen by a control read reflects every pair that closed on an earlier edge. The driver raises each request at a falling edge and pushes the expected word into a queue. It computes that word from its own cycle-accurate count and enable state, which change only at rising edges. A monitor pops the queue at the falling edge after each `rvalid_o`, so each result is compared half a cycle after it settles. Carry cases are forced by waiting until the reference lower word reaches a chosen value, with the bench built with a narrow word so that the carry comes within a few hundred cycles.

// File: rtl/snap_counter_pkg.sv
package snap_counter_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LOW  = 2'd2,
    SEL_HIGH = 2'd3
  } reg_sel_e;

  typedef enum logic {
    TRK_IDLE  = 1'b0,
    TRK_ARMED = 1'b1
  } trk_state_e;
endpackage

// File: rtl/snap_counter_decode.sv
module snap_counter_decode
  import snap_counter_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 12'h104,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h105
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  output reg_sel_e          sel_o,
  output logic              rd_low_o,
  output logic              rd_high_o,
  output logic              wr_ctrl_o
);
  always_comb begin
    if (addr_i == CTRL_ADDR)      sel_o = SEL_CTRL;
    else if (addr_i == LOW_ADDR)  sel_o = SEL_LOW;
    else if (addr_i == HIGH_ADDR) sel_o = SEL_HIGH;
    else                          sel_o = SEL_NONE;
  end

  assign rd_low_o  = rd_en_i && (sel_o == SEL_LOW);
  assign rd_high_o = rd_en_i && (sel_o == SEL_HIGH);
  assign wr_ctrl_o = wr_en_i && (sel_o == SEL_CTRL);
endmodule

// File: rtl/snap_counter_core.sv
module snap_counter_core #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             en_wdata_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int NUM_WORDS = CNT_W / WORD_W;

  logic [NUM_WORDS:0] carry;
  assign carry[0] = en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_o <= 1'b0;
    else if (wr_ctrl_i) en_o <= en_wdata_i;
  end

  // word-sliced ripple: each slice steps when all lower slices are full
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    assign carry[g+1] = carry[g] && (&word_q);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       word_q <= '0;
      else if (carry[g]) word_q <= word_q + 1'b1;
    end
    assign cnt_o[g*WORD_W +: WORD_W] = word_q;
  end

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> cnt_o == $past(cnt_o) + 1'b1);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> $stable(cnt_o));
endmodule

// File: rtl/snap_counter_track.sv
module snap_counter_track
  import snap_counter_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_low_i,
  input  logic              rd_high_i,
  input  logic              exc_i,
  input  logic [WORD_W-1:0] hi_word_i,
  output logic              ok_o
);
  trk_state_e        state_q;
  logic              taint_q;
  logic [WORD_W-1:0] hi_snap_q;
  logic              pair_good;

  assign pair_good = (state_q == TRK_ARMED) && !taint_q && !exc_i
                     && (hi_word_i == hi_snap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TRK_IDLE;
      taint_q   <= 1'b0;
      hi_snap_q <= '0;
      ok_o      <= 1'b0;
    end else if (rd_low_i) begin
      state_q   <= TRK_ARMED;
      taint_q   <= 1'b0;
      hi_snap_q <= hi_word_i;
      ok_o      <= 1'b0;
    end else if (rd_high_i) begin
      state_q <= TRK_IDLE;
      taint_q <= 1'b0;
      ok_o    <= pair_good;
    end else if (state_q == TRK_ARMED && exc_i) begin
      taint_q <= 1'b1;
    end
  end

  p_low_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_low_i |=> !ok_o);
  p_lone_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_high_i && !rd_low_i && state_q == TRK_IDLE) |=> !ok_o);
  p_exc_fails_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_high_i && !rd_low_i && (taint_q || exc_i)) |=> !ok_o);
  p_carry_fails_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_high_i && !rd_low_i && hi_word_i != hi_snap_q) |=> !ok_o);
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_low_i && !rd_high_i) |=> $stable(ok_o));
endmodule

// File: rtl/snap_counter.sv
module snap_counter
  import snap_counter_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 12'h104,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h105
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              exc_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int CNT_W   = 2 * WORD_W;
  localparam int OK_BIT  = WORD_W - 1;

  reg_sel_e         sel;
  logic             rd_low, rd_high, wr_ctrl;
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic             ok;
  logic [WORD_W-1:0] ctrl_word, rd_next;

  snap_counter_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR)
  ) u_decode (
    .addr_i(addr_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .sel_o(sel), .rd_low_o(rd_low), .rd_high_o(rd_high), .wr_ctrl_o(wr_ctrl)
  );

  snap_counter_core #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ctrl_i(wr_ctrl), .en_wdata_i(wdata_i[0]),
    .en_o(en), .cnt_o(cnt)
  );

  snap_counter_track #(.WORD_W(WORD_W)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_low_i(rd_low), .rd_high_i(rd_high),
    .exc_i(exc_i), .hi_word_i(cnt[CNT_W-1:WORD_W]), .ok_o(ok)
  );

  always_comb begin
    ctrl_word         = '0;
    ctrl_word[0]      = en;
    ctrl_word[OK_BIT] = ok;
    case (sel)
      SEL_CTRL: rd_next = ctrl_word;
      SEL_LOW:  rd_next = cnt[WORD_W-1:0];
      SEL_HIGH: rd_next = cnt[CNT_W-1:WORD_W];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_next;
    end
  end

  p_rvalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_low_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_low |=> rdata_o == $past(cnt[WORD_W-1:0]));
endmodule

// File: tb/sim_snap_counter.sv
module sim_snap_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_CTRL = 12'h103;
  localparam logic [AW-1:0] A_LOW  = 12'h104;
  localparam logic [AW-1:0] A_HIGH = 12'h105;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0, exc = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          rvalid;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [2*W-1:0] ref_cnt = '0;
  logic           ref_en = 1'b0;
  logic           m_armed = 1'b0, m_taint = 1'b0, m_ok = 1'b0;
  logic [W-1:0]   m_hi = '0;
  logic [W-1:0]   exp_q[$];
  string          req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_counter #(.ADDR_W(AW), .WORD_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .exc_i(exc), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // reference count and enable, stepped at the same edges (R1, R3)
  always @(posedge clk) begin
    if (rst_n) begin
      if (ref_en) ref_cnt <= ref_cnt + 1'b1;
      if (wr && addr == A_CTRL) ref_en <= wdata[0];
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R4 unexpected rvalid", 8'h01, 8'h00);
      else check(req_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  // each op is entered at a falling edge and returns at the next one
  task automatic op_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic op_exc();
    exc = 1'b1;
    if (m_armed) m_taint = 1'b1;
    @(negedge clk);
    exc = 1'b0;
  endtask

  task automatic op_read(input logic [AW-1:0] a, input logic with_exc, input string req);
    logic [W-1:0] e;
    e = '0;
    if (a == A_LOW) e = ref_cnt[W-1:0];
    else if (a == A_HIGH) e = ref_cnt[2*W-1:W];
    else if (a == A_CTRL) begin e[W-1] = m_ok; e[0] = ref_en; end
    exp_q.push_back(e);
    req_q.push_back(req);
    if (a == A_LOW) begin
      m_armed = 1'b1; m_taint = 1'b0; m_ok = 1'b0; m_hi = ref_cnt[2*W-1:W];
    end else if (a == A_HIGH) begin
      m_ok = m_armed && !m_taint && !with_exc && (m_hi == ref_cnt[2*W-1:W]);
      m_armed = 1'b0; m_taint = 1'b0;
    end else if (with_exc && m_armed) m_taint = 1'b1;
    addr = a; rd = 1'b1; exc = with_exc;
    @(negedge clk);
    rd = 1'b0; exc = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_low(input logic [W-1:0] v);
    while (ref_cnt[W-1:0] != v) @(negedge clk);
  endtask

  task automatic expect_status(input logic want, input string req);
    check({req, " model"}, {7'd0, m_ok}, {7'd0, want});
    op_read(A_CTRL, 1'b0, req);
  endtask

  task automatic finish_run();
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 rdata after reset", rdata, '0);
    check("R2 rvalid after reset", {7'd0, rvalid}, 8'h00);
    op_read(A_CTRL, 1'b0, "R2 ctrl after reset");
    op_read(A_LOW, 1'b0, "R2 low after reset");
    idle(5);
    op_read(A_LOW, 1'b0, "R3 disabled counter holds");
    op_read(A_HIGH, 1'b0, "R4 high word");

    op_write(A_CTRL, 8'h01);
    op_read(A_CTRL, 1'b0, "R3 enable readback");
    idle(4);
    op_read(A_LOW, 1'b0, "R1 low word counts");

    // clean pair
    wait_low(8'h10);
    op_read(A_LOW, 1'b0, "R4 low");
    op_read(A_HIGH, 1'b0, "R4 high");
    expect_status(1'b1, "R5 clean pair");
    expect_status(1'b1, "R10 ctrl read keeps status");

    // carry between reads
    wait_low(8'hFE);
    op_read(A_LOW, 1'b0, "R4 low before carry");
    idle(2);
    op_read(A_HIGH, 1'b0, "R1 high after carry");
    expect_status(1'b0, "R7 carry tears pair");

    // exception between reads
    wait_low(8'h20);
    op_read(A_LOW, 1'b0, "R4 low");
    op_exc();
    op_read(A_HIGH, 1'b0, "R4 high");
    expect_status(1'b0, "R6 exception between");

    // exception in the upper-word read cycle
    op_read(A_LOW, 1'b0, "R4 low");
    op_read(A_HIGH, 1'b1, "R4 high");
    expect_status(1'b0, "R6 exception with high");

    // exception in the lower-word read cycle and while idle do not count
    op_exc();
    op_read(A_LOW, 1'b1, "R4 low");
    op_read(A_HIGH, 1'b0, "R4 high");
    expect_status(1'b1, "R6 exception outside pair ignored");

    // lone upper-word read after a success
    op_read(A_HIGH, 1'b0, "R4 lone high");
    expect_status(1'b0, "R9 high without low");

    // lower-word read clears, second lower-word read restarts
    op_read(A_LOW, 1'b0, "R4 low");
    op_read(A_HIGH, 1'b0, "R4 high");
    expect_status(1'b1, "R5 pair again");
    op_read(A_LOW, 1'b0, "R4 low");
    expect_status(1'b0, "R8 low clears status");
    op_exc();
    op_read(A_LOW, 1'b0, "R4 low restart");
    op_read(A_HIGH, 1'b0, "R4 high");
    expect_status(1'b1, "R8 restart discards taint");

    // retry loop: first attempt torn by exception
    for (int tries = 0; tries < 4; tries++) begin
      op_read(A_LOW, 1'b0, "R4 retry low");
      if (tries == 0) op_exc();
      op_read(A_HIGH, 1'b0, "R4 retry high");
      op_read(A_CTRL, 1'b0, "R5 retry status");
      if (m_ok) break;
    end
    check("R5 retry converges", {7'd0, m_ok}, 8'h01);

    // disable holds value
    op_write(A_CTRL, 8'h00);
    op_read(A_LOW, 1'b0, "R3 low after disable");
    idle(7);
    op_read(A_LOW, 1'b0, "R3 low held");
    op_read(A_HIGH, 1'b0, "R3 high held");
    op_read(A_CTRL, 1'b0, "R3 enable clear readback");

    finish_run();
  end
endmodule